// File: doc/BRIEF.md
# Banked Data Pointer Register File

This block keeps a bank of 16-bit address pointers behind the single data pointer that an 8-bit microcontroller core sees. A select register chooses one entry of the bank. Every pointer operation the core performs goes to that entry only: reading or writing the high or low byte through two special-function-register locations, loading a full 16-bit immediate, or incrementing. The other entries keep their values. Software can therefore hold several external-memory addresses at once and switch between them with a single select write.

The selected entry also drives the external data-memory address that indirect moves use. Instruction decode supplies the load and increment strobes and the SFR access. The block takes care of the register bank, the address decode for its three SFR locations, the select register, the read-data path and the address output.

Top module: `banked_dptr`

## Requirements
- R1: After a synchronous active-low reset, the select field is 0 and every pointer entry holds 0x0000.
- R2: The select register sits at SFR address SEL_ADDR (default 0x40). Its field occupies bits [2:0]. A read returns the field with zeros in bits [7:3], and a write ignores bits [7:3].
- R3: A select write takes effect on the next clock. A byte write, load or increment in the same cycle acts on the entry that was selected before that write.
- R4: An SFR write to HI_ADDR (default 0x41) replaces bits [15:8] of the selected entry, and a write to LO_ADDR (default 0x42) replaces bits [7:0]. The other byte of that entry is unchanged.
- R5: Reads at HI_ADDR and LO_ADDR are combinational from the selected entry, so a read in the cycle after an update returns the new value.
- R6: A load strobe writes the 16-bit immediate into the selected entry.
- R7: An increment adds one to the 16-bit value of the selected entry. The carry passes from the low byte into the high byte in the same cycle, and 0xFFFF wraps to 0x0000.
- R8: Entries that are not selected keep their values through every write, load and increment.
- R9: When operations on the pointer collide, a load beats a byte write, and a byte write beats an increment. The operation that loses has no effect.
- R10: The external address output always equals the full 16-bit value of the selected entry.
- R11: A write to any other SFR address changes nothing, and a read of any other address returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sfr_addr | input | 8 | SFR address for the read or write |
| sfr_we | input | 1 | SFR write strobe |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | SFR read data, combinational |
| ld_en | input | 1 | Load the selected pointer with ld_value |
| ld_value | input | 16 | 16-bit immediate for a load |
| inc_en | input | 1 | Increment the selected pointer |
| xaddr | output | 16 | External data-memory address (selected pointer) |

## Verification
The bench builds the block with its default parameters: eight entries, an 8-bit SFR byte and a 16-bit pointer, with select, high-byte and low-byte addresses 0x40, 0x41 and 0x42. With these values a 3-bit select field covers every entry, so the bench can fill all eight entries with different patterns and then visit each one to confirm it kept its value. The carry from the low byte into the high byte and the wrap at 0xFFFF are also within reach. With the addresses fixed, the bench can drive a byte write, a load or an increment in the same cycle as a select write, or against each other, to check which one takes effect.

// File: rtl/dptr_pkg.sv
// Package: shared types for the banked data pointer block.
// Assumes: nothing beyond the standard language.
package dptr_pkg;

    // Which of the block's SFR locations the current address decodes to.
    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_SEL  = 2'd1,
        ACC_HI   = 2'd2,
        ACC_LO   = 2'd3
    } sfr_acc_e;

endpackage

// File: rtl/dptr_sfr_decode.sv
// Module: dptr_sfr_decode
// Decodes an SFR address into one of the three locations this block owns,
// or ACC_NONE when the address belongs elsewhere.
// Assumes: the three addresses are distinct.
module dptr_sfr_decode
    import dptr_pkg::*;
#(
    parameter int unsigned         ADDR_W   = 8,
    parameter logic [ADDR_W-1:0]   SEL_ADDR = 8'h40,
    parameter logic [ADDR_W-1:0]   HI_ADDR  = 8'h41,
    parameter logic [ADDR_W-1:0]   LO_ADDR  = 8'h42
) (
    input  logic [ADDR_W-1:0] addr,
    output sfr_acc_e          acc
);

    // Compare the address against each owned location.
    always_comb begin
        if (addr == SEL_ADDR)     acc = ACC_SEL;
        else if (addr == HI_ADDR) acc = ACC_HI;
        else if (addr == LO_ADDR) acc = ACC_LO;
        else                      acc = ACC_NONE;
    end

endmodule

// File: rtl/dptr_sel_reg.sv
// Module: dptr_sel_reg
// Holds the select field that picks the active pointer. Only the low
// SEL_W bits of a write are kept; the rest are ignored.
// Assumes: SEL_W <= DATA_W.
module dptr_sel_reg #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned SEL_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [SEL_W-1:0]  sel_q
);

    // Register the select field; synchronous active-low reset to entry 0.
    always_ff @(posedge clk) begin
        if (!rst_n)     sel_q <= '0;
        else if (wr_en) sel_q <= wdata[SEL_W-1:0];
    end

endmodule

// File: rtl/dptr_entry.sv
// Module: dptr_entry
// One pointer of the bank. It changes only while active. Priority:
// load, then high-byte write, then low-byte write, then increment.
// Assumes: the high-byte and low-byte writes are never both set.
module dptr_entry #(
    parameter int unsigned DATA_W = 8,
    localparam int unsigned PTR_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              ld_en,
    input  logic [PTR_W-1:0]  ld_value,
    input  logic              wr_hi,
    input  logic              wr_lo,
    input  logic [DATA_W-1:0] wdata,
    input  logic              inc_en,
    output logic [PTR_W-1:0]  value_q
);

    // Update the pointer from the winning operation when this entry is active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value_q <= '0;
        end else if (active) begin
            if (ld_en)       value_q <= ld_value;
            else if (wr_hi)  value_q[PTR_W-1:DATA_W] <= wdata;
            else if (wr_lo)  value_q[DATA_W-1:0] <= wdata;
            else if (inc_en) value_q <= value_q + PTR_W'(1);
        end
    end

endmodule

// File: rtl/dptr_read_mux.sv
// Module: dptr_read_mux
// Forms the SFR read data from the decoded location: the zero-extended
// select field, or one byte of the active pointer, or zero.
// Assumes: SEL_W <= DATA_W.
module dptr_read_mux
    import dptr_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned SEL_W  = 3,
    localparam int unsigned PTR_W = 2 * DATA_W
) (
    input  sfr_acc_e          acc,
    input  logic [SEL_W-1:0]  sel_q,
    input  logic [PTR_W-1:0]  ptr,
    output logic [DATA_W-1:0] rdata
);

    // Steer the addressed field onto the read bus.
    always_comb begin
        rdata = '0;
        unique case (acc)
            ACC_SEL:  rdata[SEL_W-1:0] = sel_q;
            ACC_HI:   rdata = ptr[PTR_W-1:DATA_W];
            ACC_LO:   rdata = ptr[DATA_W-1:0];
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/banked_dptr.sv
// Module: banked_dptr (top)
// A bank of NUM_PTRS pointers seen as one data pointer. The select
// register picks the active entry. SFR byte access, load and increment
// touch only that entry, and the address output follows it.
// Assumes: NUM_PTRS is a power of two and SEL_W <= DATA_W.
module banked_dptr
    import dptr_pkg::*;
#(
    parameter int unsigned       NUM_PTRS = 8,
    parameter int unsigned       DATA_W   = 8,
    parameter int unsigned       ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] SEL_ADDR = 8'h40,
    parameter logic [ADDR_W-1:0] HI_ADDR  = 8'h41,
    parameter logic [ADDR_W-1:0] LO_ADDR  = 8'h42,
    localparam int unsigned      PTR_W    = 2 * DATA_W,
    localparam int unsigned      SEL_W    = $clog2(NUM_PTRS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] sfr_addr,
    input  logic              sfr_we,
    input  logic [DATA_W-1:0] sfr_wdata,
    output logic [DATA_W-1:0] sfr_rdata,
    input  logic              ld_en,
    input  logic [PTR_W-1:0]  ld_value,
    input  logic              inc_en,
    output logic [PTR_W-1:0]  xaddr
);

    sfr_acc_e         acc;
    logic [SEL_W-1:0] sel_q;
    logic             wr_sel;
    logic             wr_hi;
    logic             wr_lo;
    logic [PTR_W-1:0] ptr_q [NUM_PTRS];

    dptr_sfr_decode #(
        .ADDR_W   (ADDR_W),
        .SEL_ADDR (SEL_ADDR),
        .HI_ADDR  (HI_ADDR),
        .LO_ADDR  (LO_ADDR)
    ) dec_i (
        .addr (sfr_addr),
        .acc  (acc)
    );

    // Turn the decoded location and the write strobe into per-field writes.
    always_comb begin
        wr_sel = sfr_we && (acc == ACC_SEL);
        wr_hi  = sfr_we && (acc == ACC_HI);
        wr_lo  = sfr_we && (acc == ACC_LO);
    end

    dptr_sel_reg #(
        .DATA_W (DATA_W),
        .SEL_W  (SEL_W)
    ) sel_i (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_sel),
        .wdata (sfr_wdata),
        .sel_q (sel_q)
    );

    for (genvar g = 0; g < NUM_PTRS; g++) begin : g_entry
        dptr_entry #(
            .DATA_W (DATA_W)
        ) entry_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .active   (sel_q == SEL_W'(g)),
            .ld_en    (ld_en),
            .ld_value (ld_value),
            .wr_hi    (wr_hi),
            .wr_lo    (wr_lo),
            .wdata    (sfr_wdata),
            .inc_en   (inc_en),
            .value_q  (ptr_q[g])
        );
    end

    // Present the selected entry as the external address.
    always_comb xaddr = ptr_q[sel_q];

    dptr_read_mux #(
        .DATA_W (DATA_W),
        .SEL_W  (SEL_W)
    ) rmux_i (
        .acc   (acc),
        .sel_q (sel_q),
        .ptr   (xaddr),
        .rdata (sfr_rdata)
    );

endmodule

// File: rtl/dptr_chk.sv
// Module: dptr_chk
// Checker for banked_dptr, attached by bind below. Relates the port
// behaviour and the select register over time.
// Assumes: it is bound to banked_dptr with matching parameters.
module dptr_chk #(
    parameter int unsigned       DATA_W   = 8,
    parameter int unsigned       ADDR_W   = 8,
    parameter int unsigned       SEL_W    = 3,
    parameter logic [ADDR_W-1:0] SEL_ADDR = 8'h40,
    parameter logic [ADDR_W-1:0] HI_ADDR  = 8'h41,
    parameter logic [ADDR_W-1:0] LO_ADDR  = 8'h42,
    localparam int unsigned      PTR_W    = 2 * DATA_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] sfr_addr,
    input logic              sfr_we,
    input logic [DATA_W-1:0] sfr_wdata,
    input logic [DATA_W-1:0] sfr_rdata,
    input logic              ld_en,
    input logic [PTR_W-1:0]  ld_value,
    input logic              inc_en,
    input logic [PTR_W-1:0]  xaddr,
    input logic [SEL_W-1:0]  sel_q
);

    logic any_wr;
    logic sel_wr;
    assign sel_wr = sfr_we && (sfr_addr == SEL_ADDR);
    assign any_wr = sfr_we && (sfr_addr == SEL_ADDR || sfr_addr == HI_ADDR
                               || sfr_addr == LO_ADDR);

    p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (xaddr == '0 && sel_q == '0));

    p_sel_update_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sel_wr |=> sel_q == $past(sfr_wdata[SEL_W-1:0]));

    p_sel_read_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_addr == SEL_ADDR) |-> (sfr_rdata >> SEL_W) == '0);

    p_hi_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_addr == HI_ADDR) |-> sfr_rdata == xaddr[PTR_W-1:DATA_W]);

    p_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_en && !sel_wr) |=> xaddr == $past(ld_value));

    p_inc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_en && !ld_en && !any_wr) |=> xaddr == PTR_W'($past(xaddr) + PTR_W'(1)));

    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc_en && !ld_en && !any_wr) |=> $stable(xaddr));

endmodule

bind banked_dptr dptr_chk #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .SEL_W    (SEL_W),
    .SEL_ADDR (SEL_ADDR),
    .HI_ADDR  (HI_ADDR),
    .LO_ADDR  (LO_ADDR)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .sfr_addr  (sfr_addr),
    .sfr_we    (sfr_we),
    .sfr_wdata (sfr_wdata),
    .sfr_rdata (sfr_rdata),
    .ld_en     (ld_en),
    .ld_value  (ld_value),
    .inc_en    (inc_en),
    .xaddr     (xaddr),
    .sel_q     (sel_q)
);

// File: tb/banked_dptr_tb_top.sv
// Bench for banked_dptr: a table pass over all entries, then directed
// tests for reset, carries, select timing, priority and foreign addresses.
module banked_dptr_tb_top;

    localparam time CLK_PERIOD = 10ns;
    localparam logic [7:0] A_SEL = 8'h40;
    localparam logic [7:0] A_HI  = 8'h41;
    localparam logic [7:0] A_LO  = 8'h42;
    localparam logic [7:0] A_OTH = 8'h10;

    typedef struct packed {
        logic [2:0]  sel;
        logic [15:0] val;
        logic [7:0]  hi;
        logic [7:0]  lo;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{3'd0, 16'h1234, 8'h12, 8'h34},
        '{3'd1, 16'hABCD, 8'hAB, 8'hCD},
        '{3'd2, 16'h00FF, 8'h00, 8'hFF},
        '{3'd3, 16'hFFFF, 8'hFF, 8'hFF},
        '{3'd4, 16'h8000, 8'h80, 8'h00},
        '{3'd5, 16'h0001, 8'h00, 8'h01},
        '{3'd6, 16'h5A5A, 8'h5A, 8'h5A},
        '{3'd7, 16'hC3E1, 8'hC3, 8'hE1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  sfr_addr = '0;
    logic        sfr_we = 1'b0;
    logic [7:0]  sfr_wdata = '0;
    logic [7:0]  sfr_rdata;
    logic        ld_en = 1'b0;
    logic [15:0] ld_value = '0;
    logic        inc_en = 1'b0;
    logic [15:0] xaddr;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    banked_dptr dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sfr_addr  (sfr_addr),
        .sfr_we    (sfr_we),
        .sfr_wdata (sfr_wdata),
        .sfr_rdata (sfr_rdata),
        .ld_en     (ld_en),
        .ld_value  (ld_value),
        .inc_en    (inc_en),
        .xaddr     (xaddr)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One clock with the given stimulus; called and returns at a falling edge.
    task automatic cyc(input logic we, input logic [7:0] a, input logic [7:0] d,
                       input logic ld, input logic [15:0] lv, input logic inc);
        sfr_we = we; sfr_addr = a; sfr_wdata = d;
        ld_en = ld; ld_value = lv; inc_en = inc;
        @(posedge clk);
        @(negedge clk);
        sfr_we = 1'b0; ld_en = 1'b0; inc_en = 1'b0; sfr_addr = A_OTH;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        sfr_addr = a;
        #1;
        d = sfr_rdata;
    endtask

    task automatic sel(input logic [2:0] s);
        cyc(1'b1, A_SEL, {5'b0, s}, 1'b0, '0, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state of every entry and the select field
        rd(A_SEL, r); chk("R1 sel", {8'h0, r}, 16'h0000);
        for (int i = 0; i < 8; i++) begin
            sel(3'(i));
            chk("R1 entry", xaddr, 16'h0000);
        end

        // Table pass: R6 load, R10 address, R5 byte reads
        for (int i = 0; i < 8; i++) begin
            sel(VECS[i].sel);
            cyc(1'b0, A_OTH, 8'h00, 1'b1, VECS[i].val, 1'b0);
            chk("R6/R10 load", xaddr, VECS[i].val);
            rd(A_HI, r); chk("R5 hi", {8'h0, r}, {8'h0, VECS[i].hi});
            rd(A_LO, r); chk("R5 lo", {8'h0, r}, {8'h0, VECS[i].lo});
        end
        // R8: every entry kept its value
        for (int i = 0; i < 8; i++) begin
            sel(VECS[i].sel);
            chk("R8 retain", xaddr, VECS[i].val);
        end

        // R7: carry into high byte and wrap
        sel(3'd2);
        cyc(1'b0, A_OTH, 8'h00, 1'b0, '0, 1'b1);
        chk("R7 carry", xaddr, 16'h0100);
        rd(A_HI, r); chk("R5 hi after inc", {8'h0, r}, 16'h0001);
        sel(3'd3);
        cyc(1'b0, A_OTH, 8'h00, 1'b0, '0, 1'b1);
        chk("R7 wrap", xaddr, 16'h0000);

        // R2: upper bits of select write ignored, read shows zeros
        cyc(1'b1, A_SEL, 8'hFD, 1'b0, '0, 1'b0);
        rd(A_SEL, r); chk("R2 sel read", {8'h0, r}, 16'h0005);
        chk("R2 sel effect", xaddr, 16'h0001);

        // R3: increment with a select write hits the old entry
        cyc(1'b1, A_SEL, 8'h06, 1'b0, '0, 1'b1);
        chk("R3 new sel", xaddr, 16'h5A5A);
        sel(3'd5);
        chk("R3 old entry inc", xaddr, 16'h0002);

        // R9: byte write beats increment
        sel(3'd0);
        cyc(1'b1, A_LO, 8'h77, 1'b0, '0, 1'b1);
        chk("R9 wr over inc", xaddr, 16'h1277);
        // R9: load beats byte write
        cyc(1'b1, A_HI, 8'h99, 1'b1, 16'h4444, 1'b0);
        chk("R9 ld over wr", xaddr, 16'h4444);

        // R4: high byte write keeps low byte
        sel(3'd1);
        cyc(1'b1, A_HI, 8'h11, 1'b0, '0, 1'b0);
        chk("R4 hi write", xaddr, 16'h11CD);
        cyc(1'b1, A_LO, 8'hEE, 1'b0, '0, 1'b0);
        chk("R4 lo write", xaddr, 16'h11EE);
        sel(3'd7);
        chk("R8 other entry", xaddr, 16'hC3E1);

        // R11: foreign address write has no effect, read returns zero
        cyc(1'b1, A_OTH, 8'h55, 1'b0, '0, 1'b0);
        chk("R11 no effect", xaddr, 16'hC3E1);
        rd(A_SEL, r); chk("R11 sel kept", {8'h0, r}, 16'h0007);
        rd(A_OTH, r); chk("R11 read zero", {8'h0, r}, 16'h0000);

        // R1: reset mid-run clears loaded entries
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rerun entry0", xaddr, 16'h0000);
        sel(3'd7);
        chk("R1 rerun entry7", xaddr, 16'h0000);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule